// File: doc/BRIEF.md
# Paged Memory Controller Address Decoder

This block sits between a processor with a 26-bit address bus and a 4 MB DRAM array, a ROM and a set of I/O devices. It sorts each request into one of three fixed regions by the top address bits. The low half of the space holds task memory. It is addressed logically and translated page by page. The next quarter reaches physical RAM directly, with no translation. The top quarter is shared by ROM and I/O: a read selects the ROM and a write selects the I/O devices at the same address.

Translation uses a small associative table. Every slot holds a logical page number, a physical page number, a two-bit protection code and a valid flag. The table is loaded through a one-cycle write port. Any logical page can be placed on any physical page, so each task can see its memory starting at the same low logical address. A two-bit input selects a page size of 8, 16 or 32 KB. This input decides where the page number and the offset split in the logical address. Lookup, protection check and output selection are purely combinational. Abort is therefore raised in the same cycle as the address it refuses.

Top module: `mmd_addr_decoder`

## Requirements
- R1: With `cpu_req` high, `region` reports 0 when `cpu_addr[25]` is 0 (logical), 1 when `cpu_addr[25:24]` is 2'b10 (direct physical), and 2 when it is 2'b11 (ROM/I/O).
- R2: In the ROM/I/O region a read asserts only `rom_rd` and a write asserts only `io_wr`, in both processor modes. At most one of `ram_sel`, `rom_rd`, `io_wr`, `abort` is ever high.
- R3: In the direct physical region a supervisor access (`cpu_user`=0) asserts `ram_sel` with `ram_addr` = `cpu_addr[21:0]`. A user access aborts.
- R4: `page_size` 2'b00 selects 8 KB pages, 2'b01 selects 16 KB, and 2'b10 or 2'b11 selects 32 KB. The logical page number is `cpu_addr[24:0]` shifted right by 13, 14 or 15, and the offset is the bits below that point.
- R5: A table write (`tbl_we` high at a rising edge) stores lpn, ppn, protection and valid into slot `tbl_ppn[3:0]` (16 slots by default). It is visible from the next cycle. Reset clears every valid flag.
- R6: A logical access that hits a valid slot whose stored lpn equals the address page number, and is permitted, asserts `ram_sel` with `ram_addr` = ((ppn << shift) | offset) truncated to 22 bits.
- R7: A logical access that matches no valid slot aborts. Whenever `abort` is high, `ram_sel` is low and `ram_addr` is zero.
- R8: Protection code 2'b00 allows every access, and code 2'b11 aborts every access.
- R9: Protection code 2'b01 aborts user-mode accesses and allows supervisor accesses.
- R10: Protection code 2'b10 aborts writes in either mode and allows reads.
- R11: When several valid slots match, the lowest-numbered slot supplies the translation and the protection.
- R12: With `cpu_req` low, `region` is 3 and `ram_sel`, `rom_rd`, `io_wr`, `abort` are low, with `ram_addr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table write port |
| rst_n | input | 1 | Active-low asynchronous reset, clears table valid flags |
| cpu_req | input | 1 | Access request qualifier |
| cpu_addr | input | 26 | Processor byte address |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_user | input | 1 | 1 = user mode, 0 = supervisor |
| page_size | input | 2 | Page size select (R4) |
| tbl_we | input | 1 | Table write strobe |
| tbl_lpn | input | 12 | Logical page number to store |
| tbl_ppn | input | 9 | Physical page number to store, low bits pick the slot |
| tbl_prot | input | 2 | Protection code to store |
| tbl_valid | input | 1 | Valid flag to store |
| region | output | 2 | Decoded region code |
| ram_sel | output | 1 | DRAM access granted |
| ram_addr | output | 22 | DRAM byte address |
| rom_rd | output | 1 | ROM read select |
| io_wr | output | 1 | I/O write select |
| abort | output | 1 | Access refused |

## Verification
Logical accesses are drawn from a small pool of page numbers against a table loaded with random entries. This makes hits, misses and multi-slot matches common, and a wrong priority order or a wrong compare width shows up as a wrong physical page. Page size changes from one access to the next, so an offset mask or shift stuck at one size gives wrong addresses for the other sizes. Every protection code is combined with all four mode and direction pairs, which separates the user-only rule from the read-only rule. Directed cases cover the empty table after reset, a slot cleared by an invalid write, the ROM/I/O split under both modes and user access to direct RAM.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

   typedef enum logic [1:0] {
      REG_LOGICAL  = 2'd0,
      REG_PHYSICAL = 2'd1,
      REG_ROMIO    = 2'd2,
      REG_IDLE     = 2'd3
   } mmd_region_e;

   typedef enum logic [1:0] {
      PROT_FULL   = 2'd0,
      PROT_SUPER  = 2'd1,
      PROT_RDONLY = 2'd2,
      PROT_NONE   = 2'd3
   } mmd_prot_e;

endpackage

// File: rtl/mmd_region_dec.sv
module mmd_region_dec
   import mmd_pkg::*;
(
   input  logic        req,
   input  logic [1:0]  top_bits,
   output mmd_region_e region
);

   always_comb begin
      if (!req)
         region = REG_IDLE;
      else if (!top_bits[1])
         region = REG_LOGICAL;
      else if (!top_bits[0])
         region = REG_PHYSICAL;
      else
         region = REG_ROMIO;
   end

endmodule

// File: rtl/mmd_page_cam.sv
module mmd_page_cam
   import mmd_pkg::*;
#(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned LPN_W   = 12,
   parameter int unsigned PPN_W   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LPN_W-1:0] wr_lpn,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [1:0]       wr_prot,
   input  logic             wr_valid,
   input  logic [LPN_W-1:0] look_lpn,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   output mmd_prot_e        hit_prot
);

   localparam int unsigned SLOT_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] valid_q;
   logic [LPN_W-1:0]   lpn_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   mmd_prot_e          prot_q [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [SLOT_W-1:0]  wr_slot;

   assign wr_slot = wr_ppn[SLOT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (wr_en)
         valid_q[wr_slot] <= wr_valid;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         lpn_q[wr_slot]  <= wr_lpn;
         ppn_q[wr_slot]  <= wr_ppn;
         prot_q[wr_slot] <= mmd_prot_e'(wr_prot);
      end
   end

   for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
      assign match[s] = valid_q[s] && (lpn_q[s] == look_lpn);
   end

   // lowest slot overrides: scan from the top down
   always_comb begin
      hit      = 1'b0;
      hit_ppn  = '0;
      hit_prot = PROT_FULL;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit      = 1'b1;
            hit_ppn  = ppn_q[i];
            hit_prot = prot_q[i];
         end
      end
   end

   AST_TABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_valid) |=> (valid_q[$past(wr_slot)] && lpn_q[$past(wr_slot)] == $past(wr_lpn))); // R5

   AST_TABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_valid) |=> !valid_q[$past(wr_slot)]); // R5

endmodule

// File: rtl/mmd_prot_chk.sv
module mmd_prot_chk
   import mmd_pkg::*;
(
   input  mmd_prot_e prot,
   input  logic      wr,
   input  logic      user,
   output logic      deny
);

   always_comb begin
      case (prot)
         PROT_FULL:   deny = 1'b0;
         PROT_SUPER:  deny = user;
         PROT_RDONLY: deny = wr;
         default:     deny = 1'b1;
      endcase
   end

endmodule

// File: rtl/mmd_addr_decoder.sv
module mmd_addr_decoder
   import mmd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 26,
   parameter int unsigned PHYS_W    = 22,
   parameter int unsigned MIN_SHIFT = 13,
   parameter int unsigned ENTRIES   = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cpu_req,
   input  logic [ADDR_W-1:0]            cpu_addr,
   input  logic                         cpu_wr,
   input  logic                         cpu_user,
   input  logic [1:0]                   page_size,
   input  logic                         tbl_we,
   input  logic [ADDR_W-2-MIN_SHIFT:0]  tbl_lpn,
   input  logic [PHYS_W-1-MIN_SHIFT:0]  tbl_ppn,
   input  logic [1:0]                   tbl_prot,
   input  logic                         tbl_valid,
   output logic [1:0]                   region,
   output logic                         ram_sel,
   output logic [PHYS_W-1:0]            ram_addr,
   output logic                         rom_rd,
   output logic                         io_wr,
   output logic                         abort
);

   localparam int unsigned LOG_W = ADDR_W - 1;
   localparam int unsigned LPN_W = LOG_W - MIN_SHIFT;
   localparam int unsigned PPN_W = PHYS_W - MIN_SHIFT;

   if (LOG_W > 31) begin : g_bad_addr
      $error("mmd_addr_decoder: ADDR_W too wide for the translation path");
   end
   if (MIN_SHIFT + 2 >= PHYS_W) begin : g_bad_page
      $error("mmd_addr_decoder: largest page must fit inside PHYS_W");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0 || ENTRIES > (1 << PPN_W)) begin : g_bad_entries
      $error("mmd_addr_decoder: ENTRIES must be a power of two up to the page count");
   end

   mmd_region_e      reg_dec;
   logic             cam_hit;
   logic [PPN_W-1:0] cam_ppn;
   mmd_prot_e        cam_prot;
   logic             denied;
   logic [5:0]       shift;
   logic [LOG_W-1:0] log_addr;
   logic [LOG_W-1:0] lpn_wide;
   logic [LOG_W-1:0] off_mask;
   logic [LOG_W-1:0] offset;
   logic [31:0]      xlat;

   always_comb begin
      case (page_size)
         2'b00:   shift = 6'(MIN_SHIFT);
         2'b01:   shift = 6'(MIN_SHIFT + 1);
         default: shift = 6'(MIN_SHIFT + 2);
      endcase
      log_addr = cpu_addr[LOG_W-1:0];
      lpn_wide = log_addr >> shift;
      off_mask = (LOG_W'(1) << shift) - LOG_W'(1);
      offset   = log_addr & off_mask;
      xlat     = (32'(cam_ppn) << shift) | 32'(offset);
   end

   mmd_region_dec i_region_dec (
      .req      (cpu_req),
      .top_bits (cpu_addr[ADDR_W-1:ADDR_W-2]),
      .region   (reg_dec)
   );

   mmd_page_cam #(
      .ENTRIES (ENTRIES),
      .LPN_W   (LPN_W),
      .PPN_W   (PPN_W)
   ) i_page_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_lpn   (tbl_lpn),
      .wr_ppn   (tbl_ppn),
      .wr_prot  (tbl_prot),
      .wr_valid (tbl_valid),
      .look_lpn (lpn_wide[LPN_W-1:0]),
      .hit      (cam_hit),
      .hit_ppn  (cam_ppn),
      .hit_prot (cam_prot)
   );

   mmd_prot_chk i_prot_chk (
      .prot (cam_prot),
      .wr   (cpu_wr),
      .user (cpu_user),
      .deny (denied)
   );

   always_comb begin
      region   = reg_dec;
      ram_sel  = 1'b0;
      ram_addr = '0;
      rom_rd   = 1'b0;
      io_wr    = 1'b0;
      abort    = 1'b0;
      case (reg_dec)
         REG_LOGICAL: begin
            if (!cam_hit || denied) begin
               abort = 1'b1;
            end else begin
               ram_sel  = 1'b1;
               ram_addr = xlat[PHYS_W-1:0];
            end
         end
         REG_PHYSICAL: begin
            if (cpu_user) begin
               abort = 1'b1;
            end else begin
               ram_sel  = 1'b1;
               ram_addr = cpu_addr[PHYS_W-1:0];
            end
         end
         REG_ROMIO: begin
            rom_rd = !cpu_wr;
            io_wr  = cpu_wr;
         end
         default: ;
      endcase
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_sel, rom_rd, io_wr, abort})); // R2

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (!ram_sel && ram_addr == '0)); // R7

   AST_PHYS_USER: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b10 && cpu_user) |-> abort); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> (!ram_sel && !rom_rd && !io_wr && !abort)); // R12

   AST_NONE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_dec == REG_LOGICAL && cam_hit && cam_prot == PROT_NONE) |-> abort); // R8

   AST_RDONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_dec == REG_LOGICAL && cam_hit && cam_prot == PROT_RDONLY && cpu_wr) |-> abort); // R10

   AST_USER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_dec == REG_LOGICAL && cam_hit && cam_prot == PROT_SUPER && cpu_user) |-> abort); // R9

endmodule

// File: tb/test_mmd_addr_decoder.sv
`timescale 1ns/1ps
module test_mmd_addr_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [25:0] cpu_addr = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_user = 1'b0;
   logic [1:0]  page_size = 2'b00;
   logic        tbl_we = 1'b0;
   logic [11:0] tbl_lpn = '0;
   logic [8:0]  tbl_ppn = '0;
   logic [1:0]  tbl_prot = '0;
   logic        tbl_valid = 1'b0;
   logic [1:0]  region;
   logic        ram_sel;
   logic [21:0] ram_addr;
   logic        rom_rd;
   logic        io_wr;
   logic        abort;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic        t_v  [16];
   logic [11:0] t_l  [16];
   logic [8:0]  t_p  [16];
   logic [1:0]  t_pr [16];
   string       exp_tag;

   always #2 clk = ~clk;

   mmd_addr_decoder i_mmd_addr_decoder (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_wr(cpu_wr), .cpu_user(cpu_user), .page_size(page_size),
      .tbl_we(tbl_we), .tbl_lpn(tbl_lpn), .tbl_ppn(tbl_ppn),
      .tbl_prot(tbl_prot), .tbl_valid(tbl_valid), .region(region),
      .ram_sel(ram_sel), .ram_addr(ram_addr), .rom_rd(rom_rd),
      .io_wr(io_wr), .abort(abort)
   );

   function automatic int shift_of(input logic [1:0] ps);
      return (ps == 2'b00) ? 13 : (ps == 2'b01) ? 14 : 15;
   endfunction

   // expected {region, ram_sel, ram_addr, rom_rd, io_wr, abort}
   function automatic logic [27:0] model(input logic req, input logic [25:0] a,
                                         input logic wr, input logic usr,
                                         input logic [1:0] ps);
      int          sh;
      logic [11:0] lpn;
      logic [31:0] off;
      logic [31:0] pa;
      int          hit;
      sh = shift_of(ps);
      if (!req) begin
         exp_tag = "R12";
         return {2'd3, 1'b0, 22'd0, 3'b000};
      end
      if (a[25:24] == 2'b11) begin
         exp_tag = "R2";
         return {2'd2, 1'b0, 22'd0, !wr, wr, 1'b0};
      end
      if (a[25:24] == 2'b10) begin
         exp_tag = "R3";
         if (usr) return {2'd1, 1'b0, 22'd0, 3'b001};
         return {2'd1, 1'b1, a[21:0], 3'b000};
      end
      lpn = 12'(32'(a[24:0]) >> sh);
      hit = -1;
      for (int i = 15; i >= 0; i--)
         if (t_v[i] && t_l[i] == lpn) hit = i;
      if (hit < 0) begin
         exp_tag = "R7";
         return {2'd0, 1'b0, 22'd0, 3'b001};
      end
      case (t_pr[hit])
         2'd0: exp_tag = "R8";
         2'd1: exp_tag = "R9";
         2'd2: exp_tag = "R10";
         default: exp_tag = "R8";
      endcase
      if (t_pr[hit] == 2'd3 || (t_pr[hit] == 2'd1 && usr) || (t_pr[hit] == 2'd2 && wr))
         return {2'd0, 1'b0, 22'd0, 3'b001};
      off = 32'(a[24:0]) & ((32'd1 << sh) - 32'd1);
      pa  = (32'(t_p[hit]) << sh) | off;
      if (exp_tag == "R8") exp_tag = "R6";
      return {2'd0, 1'b1, pa[21:0], 3'b000};
   endfunction

   task automatic check(input string tag, input logic [27:0] exp);
      logic [27:0] got;
      got = {region, ram_sel, ram_addr, rom_rd, io_wr, abort};
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h (addr %h wr %b user %b ps %b)",
                  tag, got, exp, cpu_addr, cpu_wr, cpu_user, page_size);
      end
   endtask

   task automatic tbl_write(input logic [11:0] l, input logic [8:0] p,
                            input logic [1:0] pr, input logic v);
      @(negedge clk);
      tbl_we = 1'b1; tbl_lpn = l; tbl_ppn = p; tbl_prot = pr; tbl_valid = v;
      @(negedge clk);
      tbl_we = 1'b0;
      t_v[p[3:0]] = v; t_l[p[3:0]] = l; t_p[p[3:0]] = p; t_pr[p[3:0]] = pr;
   endtask

   task automatic access(input string tag, input logic req, input logic [25:0] a,
                         input logic wr, input logic usr, input logic [1:0] ps);
      logic [27:0] e;
      @(negedge clk);
      cpu_req = req; cpu_addr = a; cpu_wr = wr; cpu_user = usr; page_size = ps;
      #1;
      e = model(req, a, wr, usr, ps);
      check((tag == "") ? exp_tag : tag, e);
   endtask

   function automatic logic [25:0] log_addr(input logic [11:0] l, input logic [1:0] ps,
                                            input logic [31:0] o);
      int sh;
      logic [31:0] v;
      sh = shift_of(ps);
      v = (32'(l) << sh) | (o & ((32'd1 << sh) - 32'd1));
      return {1'b0, v[24:0]};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      for (int i = 0; i < 16; i++) begin
         t_v[i] = 1'b0; t_l[i] = '0; t_p[i] = '0; t_pr[i] = '0;
      end
      // R12 reset state
      #1;
      check("R12", {2'd3, 1'b0, 22'd0, 3'b000});
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R5 empty table after reset: logical access misses
      access("R5", 1'b1, 26'h0000100, 1'b0, 1'b0, 2'b00);
      // R1 region codes
      access("R1", 1'b1, 26'h2345678, 1'b0, 1'b0, 2'b00);
      access("R1", 1'b1, 26'h3ABCDEF, 1'b0, 1'b1, 2'b00);
      // R2 ROM/IO split in both modes
      access("R2", 1'b1, 26'h3000040, 1'b0, 1'b1, 2'b01);
      access("R2", 1'b1, 26'h3000040, 1'b1, 1'b1, 2'b01);
      access("R2", 1'b1, 26'h3FFFFFC, 1'b1, 1'b0, 2'b10);
      // R3 direct physical
      access("R3", 1'b1, 26'h2FFFFFF, 1'b1, 1'b0, 2'b00);
      access("R3", 1'b1, 26'h2000010, 1'b0, 1'b1, 2'b00);
      // R5/R6 load then hit at each page size (R4)
      tbl_write(12'h004, 9'h1A2, 2'd0, 1'b1);
      access("R6", 1'b1, log_addr(12'h004, 2'b00, 32'h1234), 1'b1, 1'b1, 2'b00);
      access("R4", 1'b1, log_addr(12'h004, 2'b01, 32'h2345), 1'b0, 1'b1, 2'b01);
      access("R4", 1'b1, log_addr(12'h004, 2'b10, 32'h7FFF), 1'b0, 1'b0, 2'b10);
      access("R4", 1'b1, log_addr(12'h004, 2'b11, 32'h0001), 1'b0, 1'b0, 2'b11);
      // R9 supervisor-only page
      tbl_write(12'h010, 9'h005, 2'd1, 1'b1);
      access("R9", 1'b1, log_addr(12'h010, 2'b00, 32'h0), 1'b0, 1'b1, 2'b00);
      access("R9", 1'b1, log_addr(12'h010, 2'b00, 32'h8), 1'b1, 1'b0, 2'b00);
      // R10 read-only page
      tbl_write(12'h011, 9'h006, 2'd2, 1'b1);
      access("R10", 1'b1, log_addr(12'h011, 2'b00, 32'h4), 1'b1, 1'b0, 2'b00);
      access("R10", 1'b1, log_addr(12'h011, 2'b00, 32'h4), 1'b0, 1'b1, 2'b00);
      // R8 no-access page
      tbl_write(12'h012, 9'h007, 2'd3, 1'b1);
      access("R8", 1'b1, log_addr(12'h012, 2'b00, 32'h4), 1'b0, 1'b0, 2'b00);
      // R11 two slots with the same lpn: slot 3 beats slot 9
      tbl_write(12'h040, 9'h109, 2'd0, 1'b1);
      tbl_write(12'h040, 9'h0E3, 2'd2, 1'b1);
      access("R11", 1'b1, log_addr(12'h040, 2'b00, 32'h10), 1'b0, 1'b0, 2'b00);
      access("R11", 1'b1, log_addr(12'h040, 2'b00, 32'h10), 1'b1, 1'b0, 2'b00);
      // R5 invalid write clears the slot; slot 9 then serves
      tbl_write(12'h040, 9'h0E3, 2'd0, 1'b0);
      access("R5", 1'b1, log_addr(12'h040, 2'b00, 32'h10), 1'b1, 1'b0, 2'b00);
      // R7 miss
      access("R7", 1'b1, log_addr(12'h7FF, 2'b00, 32'h10), 1'b0, 1'b0, 2'b00);
      // R12 idle with an address present
      access("R12", 1'b0, 26'h3000000, 1'b1, 1'b0, 2'b00);

      // random table with a small lpn pool
      for (int k = 0; k < 40; k++)
         tbl_write(12'($urandom % 8), 9'($urandom), 2'($urandom), ($urandom % 6) != 0);
      for (int k = 0; k < 3000; k++) begin
         logic [1:0]  ps;
         logic [25:0] a;
         int          sel;
         ps  = 2'($urandom);
         sel = int'($urandom % 8);
         if (sel == 0)      a = {2'b10, 24'($urandom)};
         else if (sel == 1) a = {2'b11, 24'($urandom)};
         else if (sel == 2) a = {1'b0, 25'($urandom)};
         else               a = log_addr(12'($urandom % 9), ps, $urandom);
         access("", ($urandom % 16) != 0, a, 1'($urandom), 1'($urandom), ps);
         if (k % 300 == 299)
            tbl_write(12'($urandom % 8), 9'($urandom), 2'($urandom), 1'b1);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule